// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers interrupt requests from a set of hardware sources (on-chip peripherals and external pins) plus one software-raised source, and maps each onto one of eight priority levels chosen by software. Requests are recorded per level in a pending register. The block presents the most urgent pending level and its service-routine vector address to the processor core. It does so only while the global enable input is high and only when that level outranks every level currently being serviced.

The core takes an offered interrupt by pulsing the acknowledge input. That moves the granted level from pending to in-service. It ends a service routine by pulsing end-of-service, which retires the most urgent in-service level. Lower-priority work can therefore be preempted and nested. Clearing the global enable only holds back the request output. New requests keep being recorded and are offered as soon as the enable returns.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, no level is pending or in service, and every source is masked with level 0.
- R2: A request from a masked source is not recorded. Unmasking that source later does not produce an interrupt from the earlier request.
- R3: A request from an unmasked source assigned level L sets pending bit L. With the enable high and nothing in service, `irq_o` is high and `irq_lvl_o` equals L on the cycle after the request.
- R4: While `gie_i` is low, `irq_o` stays low and requests are still recorded. Raising `gie_i` asserts `irq_o` in the same cycle.
- R5: Among pending levels the highest number wins. Level 7 is most urgent and level 0 least.
- R6: `irq_vec_o` equals VEC_BASE + level × VEC_STRIDE, which is 0x040 + 4 × level by default.
- R7: An acknowledge while `irq_o` is high clears the offered level's pending bit and sets its in-service bit. An acknowledge while `irq_o` is low changes nothing.
- R8: `irq_o` is asserted only when the highest pending level is strictly above the highest in-service level. An equal or lower pending level waits.
- R9: An end-of-service pulse clears only the highest set in-service bit.
- R10: Several sources sharing one level merge into one pending bit, and a single acknowledge clears it.
- R11: The software source is configured at address NUM_SRC. Any write to address NUM_SRC+1 raises a request from it.
- R12: A configuration write to address s (s ≤ NUM_SRC) stores wdata bit 3 as the unmask flag (1 = enabled) and bits 2:0 as the level. Writes to higher addresses have no effect.
- R13: A new request at the level being acknowledged in the same cycle stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NUM_SRC | Hardware request lines, one per source, sampled each cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration address |
| cfg_wdata_i | input | 4 | Write data: bit 3 unmask, bits 2:0 level |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Core accepts the offered interrupt |
| eoi_i | input | 1 | Core finished the current service routine |
| irq_o | output | 1 | Interrupt offered to the core |
| irq_lvl_o | output | 3 | Level of the offered interrupt |
| irq_vec_o | output | VEC_W | Vector address of the offered level |

## Verification
The assertions assume that the core pulses end-of-service once per acknowledged interrupt. They also assume that acknowledge and end-of-service are single-cycle strobes sampled on the clock edge.

The bench does not keep the core's handshake polite. Its random phase raises acknowledge at arbitrary times, including while no interrupt is offered, and raises end-of-service whether or not any level is in service. This is how the ignore paths of R7 and R9 are exercised. Configuration writes take random addresses over the whole address space, so unmapped addresses and live reconfiguration with requests in flight are both covered.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = $clog2(NUM_LVL);

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvlvec_t;

  // one configuration slot per source
  typedef struct packed {
    logic en;
    lvl_t lvl;
  } src_cfg_t;
endpackage

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc
  import irq_pkg::*;
(
  input  lvlvec_t vec_i,
  output lvl_t    idx_o,
  output logic    vld_o
);
  // highest set bit wins; later iterations override earlier ones
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (vec_i[i]) idx_o = lvl_t'(i);
    end
    vld_o = |vec_i;
  end
endmodule

// File: rtl/irq_src_cfg.sv
`timescale 1ns/1ps
module irq_src_cfg
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [3:0]         cfg_wdata_i,
  input  logic [NUM_SRC-1:0] hw_req_i,
  output lvlvec_t            set_vec_o
);
  localparam int TOT_SRC  = NUM_SRC + 1;
  localparam int SW_TRIG  = NUM_SRC + 1;

  logic [TOT_SRC-1:0] en_vec;
  lvl_t               lvl_arr [TOT_SRC];
  logic [TOT_SRC-1:0] req_all;
  logic               sw_fire;

  for (genvar g = 0; g < TOT_SRC; g++) begin : g_slot
    src_cfg_t slot_q, slot_d;
    logic     wr_en;

    assign wr_en = cfg_we_i && (cfg_addr_i == ADDR_W'(g));

    always_comb begin
      slot_d = slot_q;
      if (wr_en) slot_d = src_cfg_t'(cfg_wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    slot_q <= '0;
      else if (wr_en) slot_q <= slot_d;
    end

    assign en_vec[g]  = slot_q.en;
    assign lvl_arr[g] = slot_q.lvl;
  end

  assign sw_fire = cfg_we_i && (cfg_addr_i == ADDR_W'(SW_TRIG));
  assign req_all = {sw_fire, hw_req_i};

  always_comb begin
    set_vec_o = '0;
    for (int s = 0; s < TOT_SRC; s++) begin
      if (req_all[s] && en_vec[s]) set_vec_o[lvl_arr[s]] = 1'b1;
    end
  end

  // R2: nothing reaches the pending register without an enabled requester
  p_masked_no_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_all & en_vec) == '0) |-> (set_vec_o == '0));

  // R11: an enabled software trigger lands on its configured level
  p_sw_trig_sets_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_fire && en_vec[NUM_SRC]) |-> set_vec_o[lvl_arr[NUM_SRC]]);
endmodule

// File: rtl/irq_level_state.sv
`timescale 1ns/1ps
module irq_level_state
  import irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  lvlvec_t set_vec_i,
  input  logic    ack_fire_i,
  input  lvl_t    grant_lvl_i,
  input  logic    eoi_i,
  input  lvl_t    svc_top_i,
  input  logic    svc_vld_i,
  output lvlvec_t pend_o,
  output lvlvec_t isr_o
);
  lvlvec_t pend_q, pend_d, isr_q, isr_d;
  lvlvec_t ack_mask, eoi_mask;
  logic    pend_en, isr_en;

  always_comb begin
    ack_mask = ack_fire_i ? (lvlvec_t'(1) << grant_lvl_i) : '0;
    eoi_mask = (eoi_i && svc_vld_i) ? (lvlvec_t'(1) << svc_top_i) : '0;
    // a fresh request beats the clear of the same level (R13)
    pend_d   = (pend_q & ~ack_mask) | set_vec_i;
    isr_d    = (isr_q & ~eoi_mask) | ack_mask;
    pend_en  = ack_fire_i || (set_vec_i != '0);
    isr_en   = ack_fire_i || eoi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  assign pend_o = pend_q;
  assign isr_o  = isr_q;

  // R7: the granted level is in service on the next cycle
  p_ack_sets_isr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire_i |=> isr_q[$past(grant_lvl_i)]);

  // R4: without an acknowledge no pending bit is lost
  p_pend_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_fire_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R8: in-service depth grows only through an acknowledge
  p_isr_no_growth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_fire_i |=> ($countones(isr_q) <= $past($countones(isr_q))));

  // R9: end-of-service retires exactly one level
  p_eoi_drops_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_fire_i && (isr_q != '0))
      |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int ADDR_W     = $clog2(NUM_SRC + 2),
  parameter int VEC_W      = 12,
  parameter int VEC_BASE   = 'h040,
  parameter int VEC_STRIDE = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [3:0]         cfg_wdata_i,
  input  logic               gie_i,
  input  logic               irq_ack_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [2:0]         irq_lvl_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  // reset asserts at once, releases two edges later
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  lvlvec_t set_vec, pend, isr;
  lvl_t    pend_top, svc_top;
  logic    pend_vld, svc_vld;
  logic    ack_fire;

  irq_src_cfg #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_src_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .hw_req_i    (src_req_i),
    .set_vec_o   (set_vec)
  );

  irq_prio_enc u_pend_enc (.vec_i(pend), .idx_o(pend_top), .vld_o(pend_vld));
  irq_prio_enc u_svc_enc  (.vec_i(isr),  .idx_o(svc_top),  .vld_o(svc_vld));

  irq_level_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .set_vec_i   (set_vec),
    .ack_fire_i  (ack_fire),
    .grant_lvl_i (pend_top),
    .eoi_i       (eoi_i),
    .svc_top_i   (svc_top),
    .svc_vld_i   (svc_vld),
    .pend_o      (pend),
    .isr_o       (isr)
  );

  always_comb begin
    irq_o     = gie_i && pend_vld && (!svc_vld || (pend_top > svc_top));
    ack_fire  = irq_ack_i && irq_o;
    irq_lvl_o = pend_top;
    irq_vec_o = VEC_W'(VEC_BASE + int'(pend_top) * VEC_STRIDE);
  end

  // R8: an offered level is never one already in service
  p_irq_above_isr_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    irq_o |-> !isr[irq_lvl_o]);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int NSRC = 8;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_req;
  logic            cfg_we;
  logic [AW-1:0]   cfg_addr;
  logic [3:0]      cfg_wdata;
  logic            gie, irq_ack, eoi;
  logic            irq;
  logic [2:0]      irq_lvl;
  logic [11:0]     irq_vec;

  int checks = 0;
  int failures = 0;

  logic       m_en  [NSRC+1];
  logic [2:0] m_lvl [NSRC+1];
  logic [7:0] m_pend, m_isr;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src_req), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .gie_i(gie),
    .irq_ack_i(irq_ack), .eoi_i(eoi), .irq_o(irq), .irq_lvl_o(irq_lvl),
    .irq_vec_o(irq_vec)
  );

  function automatic logic [2:0] top_bit(logic [7:0] v);
    logic [2:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic exp_irq();
    return gie && (m_pend != 0) &&
           ((m_isr == 0) || (top_bit(m_pend) > top_bit(m_isr)));
  endfunction

  function automatic logic [11:0] exp_vec(logic [2:0] l);
    return 12'h040 + 12'(l) * 12'd4;
  endfunction

  task automatic tick();
    logic [NSRC:0] reqs;
    logic [7:0]    setv, clr, eclr;
    logic          ackf;
    reqs = {cfg_we && (cfg_addr == AW'(NSRC + 1)), src_req};
    setv = '0;
    for (int s = 0; s <= NSRC; s++) if (reqs[s] && m_en[s]) setv[m_lvl[s]] = 1'b1;
    ackf = irq_ack && exp_irq();
    clr  = ackf ? (8'd1 << top_bit(m_pend)) : 8'd0;
    eclr = (eoi && m_isr != 0) ? (8'd1 << top_bit(m_isr)) : 8'd0;
    @(posedge clk);
    m_pend = (m_pend & ~clr) | setv;
    m_isr  = (m_isr & ~eclr) | clr;
    if (cfg_we && int'(cfg_addr) <= NSRC) begin
      m_en[cfg_addr]  = cfg_wdata[3];
      m_lvl[cfg_addr] = cfg_wdata[2:0];
    end
    @(negedge clk);
    src_req = '0; cfg_we = 1'b0; irq_ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic cfg(input int a, input logic e, input logic [2:0] l);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = {e, l};
    tick();
  endtask

  task automatic check_lit(input string tag, input logic e_irq, input logic [2:0] e_lvl);
    checks++;
    if (irq !== e_irq || (e_irq && (irq_lvl !== e_lvl || irq_vec !== exp_vec(e_lvl)))) begin
      failures++;
      $display("FAIL %s actual irq=%0b lvl=%0d vec=%h expected irq=%0b lvl=%0d vec=%h",
               tag, irq, irq_lvl, irq_vec, e_irq, e_lvl, exp_vec(e_lvl));
    end
  endtask

  task automatic check_model(input string tag);
    check_lit(tag, exp_irq(), top_bit(m_pend));
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; failures++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s <= NSRC; s++) begin m_en[s] = 1'b0; m_lvl[s] = '0; end
    m_pend = '0; m_isr = '0;
    rst_n = 1'b0; src_req = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    gie = 1'b0; irq_ack = 1'b0; eoi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_lit("R1 reset", 1'b0, 3'd0);

    gie = 1'b1; src_req = 8'h01; tick();
    check_lit("R2 masked request", 1'b0, 3'd0);
    cfg(0, 1'b1, 3'd2);
    check_lit("R2 no memory after unmask", 1'b0, 3'd0);
    src_req = 8'h01; tick();
    check_lit("R3 R6 level 2", 1'b1, 3'd2);

    gie = 1'b0; #1;
    check_lit("R4 gated", 1'b0, 3'd0);
    cfg(1, 1'b1, 3'd5);
    src_req = 8'h02; tick();
    check_lit("R4 recorded while off", 1'b0, 3'd0);
    gie = 1'b1; #1;
    check_lit("R4 R5 resume highest", 1'b1, 3'd5);

    irq_ack = 1'b1; tick();
    check_lit("R7 R8 ack blocks lower", 1'b0, 3'd0);
    cfg(2, 1'b1, 3'd5);
    src_req = 8'h04; tick();
    check_lit("R8 equal level waits", 1'b0, 3'd0);
    cfg(3, 1'b1, 3'd7);
    src_req = 8'h08; tick();
    check_lit("R5 R8 preempt", 1'b1, 3'd7);
    irq_ack = 1'b1; tick();
    check_lit("R7 nested ack", 1'b0, 3'd0);
    eoi = 1'b1; tick();
    check_lit("R9 top retired only", 1'b0, 3'd0);
    eoi = 1'b1; tick();
    check_lit("R9 second retire", 1'b1, 3'd5);
    irq_ack = 1'b1; tick();
    eoi = 1'b1; tick();
    check_lit("R9 lower resumes", 1'b1, 3'd2);
    irq_ack = 1'b1; tick();
    eoi = 1'b1; tick();
    check_lit("R7 drained", 1'b0, 3'd0);

    src_req = 8'h06; tick();
    check_lit("R10 merged level", 1'b1, 3'd5);
    irq_ack = 1'b1; tick();
    eoi = 1'b1; tick();
    check_lit("R10 one ack clears", 1'b0, 3'd0);

    cfg(8, 1'b1, 3'd6);
    cfg(9, 1'b0, 3'd0);
    check_lit("R11 software source", 1'b1, 3'd6);
    irq_ack = 1'b1; tick();
    eoi = 1'b1; tick();

    cfg(12, 1'b1, 3'd7);
    check_lit("R12 unmapped write", 1'b0, 3'd0);
    cfg(0, 1'b0, 3'd2);
    src_req = 8'h01; tick();
    check_lit("R12 mask by write", 1'b0, 3'd0);

    cfg(0, 1'b1, 3'd3);
    src_req = 8'h01; tick();
    check_lit("R13 setup", 1'b1, 3'd3);
    irq_ack = 1'b1; src_req = 8'h01; tick();
    check_lit("R13 blocked by service", 1'b0, 3'd0);
    eoi = 1'b1; tick();
    check_lit("R13 request survived ack", 1'b1, 3'd3);

    gie = 1'b0; irq_ack = 1'b1; tick();
    gie = 1'b1; #1;
    check_lit("R7 ack ignored when idle", 1'b1, 3'd3);
    irq_ack = 1'b1; tick();
    eoi = 1'b1; tick();
    check_model("R7 model sync");

    for (int n = 0; n < 800; n++) begin
      gie     = ($urandom % 10) != 0;
      src_req = NSRC'($urandom & $urandom & $urandom);
      irq_ack = ($urandom % 4) == 0;
      eoi     = ($urandom % 6) == 0;
      if (($urandom % 8) == 0) begin
        cfg_we = 1'b1; cfg_addr = AW'($urandom); cfg_wdata = 4'($urandom);
      end
      tick();
      check_model("R5 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule